// File: doc/BRIEF.md
# Small I2C Memory Slave

This block is a bus slave holding sixteen bytes in flip-flops, reached over a two-wire serial bus (SCL clock, open-drain SDA data). Every bus transaction opens with a control byte. Its upper seven bits must match a fixed device identity, and its lowest bit selects the direction. A 4-bit address pointer inside the slave selects the byte that is accessed. The pointer advances after every byte that is stored or sent.

A write transaction sends the control byte and then an address byte that loads the pointer. An optional single data byte may follow, and it is stored at that pointer. A read transaction streams bytes from the pointer for as long as the master acknowledges them. After each stored byte the slave stays busy for a parameterized number of system clocks, which stands in for a nonvolatile write cycle. During that time it refuses control bytes, so the master can poll the slave until the write completes.

SCL and SDA are sampled on the system clock through synchronizer stages. Start and stop conditions are recognised as SDA edges while SCL is high. The output `sda_oe` pulls the shared SDA line low when it is 1.

Top module: `tiny_i2c_mem`

## Requirements
- R1: After reset the slave leaves SDA released, all sixteen bytes read as 0x00, and the pointer is 0.
- R2: A control byte is received MSB first. When its bits 7..1 equal 1010000 and no write cycle is pending, it is acknowledged by pulling SDA low during the ninth clock, and bit 0 is the direction (1 = read, 0 = write). Any other value is not acknowledged, and the slave then drives nothing until the next start or stop.
- R3: In a write transaction, the byte after the control byte is acknowledged only when its bits 7..4 are 0000. Its bits 3..0 then become the pointer. Otherwise it is not acknowledged and the pointer keeps its old value.
- R4: A data byte following an acknowledged address byte is stored at the pointer and acknowledged, and the pointer advances by one.
- R5: Any further byte in the same write transaction is not acknowledged and is not stored.
- R6: In a read transaction the slave sends the byte at the pointer MSB first and advances the pointer, and it keeps sending bytes while the master acknowledges. After the master does not acknowledge a byte, SDA stays released until the next start or stop.
- R7: The pointer wraps from 15 to 0, both on reads and on writes.
- R8: After a byte is stored, control bytes of either direction are not acknowledged for BUSY_CYCLES system clocks, and they are acknowledged again afterwards.
- R9: A start condition at any point, even in the middle of a byte, abandons the current transaction and expects a new control byte.
- R10: The slave changes its SDA drive only while SCL is low, never while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the open-drain data line low |

## Verification
The embedded properties watch, on every cycle, that the SDA drive never moves while the sampled SCL is high and outside a start or stop. They also check that a write makes the slave busy, that no control byte is acknowledged and no byte is stored while it is busy, and that the pointer either loads the address byte or steps by exactly one with wrap. Whether the right byte arrives at the pins, is acknowledged or refused, is retained across transactions, and is ignored after a refused byte or a master NACK can only be shown by the bench's bus-level transactions. The same holds for the busy window expiring and for repeated starts in mid-byte.

// File: rtl/tiny_i2c_mem_pkg.sv
package tiny_i2c_mem_pkg;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_RX,
        ENG_RX_ACK,
        ENG_TX,
        ENG_TX_ACK,
        ENG_IGNORE
    } eng_state_e;

    // Which byte of a write-direction transaction is being received
    typedef enum logic [1:0] {
        SEG_CTRL,
        SEG_ADDR,
        SEG_DATA,
        SEG_EXTRA
    } seg_e;

    typedef struct packed {
        logic scl_lvl;
        logic sda_lvl;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic ctrl_hits(input logic [7:0] b, input logic [6:0] id);
        return b[7:1] == id;
    endfunction

    function automatic logic addr_fits(input logic [7:0] b, input int aw);
        return (b >> aw) == 8'd0;
    endfunction

    function automatic seg_e seg_next(input seg_e s);
        case (s)
            SEG_CTRL: return SEG_ADDR;
            SEG_ADDR: return SEG_DATA;
            default:  return SEG_EXTRA;
        endcase
    endfunction

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler
    import tiny_i2c_mem_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] scl_pipe;
    logic [TOP:0] sda_pipe;
    logic         scl_prev;
    logic         sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
            sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
            scl_prev <= scl_pipe[TOP];
            sda_prev <= sda_pipe[TOP];
        end
    end

    always_comb begin
        ev.scl_lvl  = scl_pipe[TOP];
        ev.sda_lvl  = sda_pipe[TOP];
        ev.scl_rise = scl_pipe[TOP] & ~scl_prev;
        ev.scl_fall = ~scl_pipe[TOP] & scl_prev;
        ev.start    = scl_pipe[TOP] & scl_prev & sda_prev & ~sda_pipe[TOP];
        ev.stop     = scl_pipe[TOP] & scl_prev & ~sda_prev & sda_pipe[TOP];
    end

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
    parameter int DEPTH       = 16,
    parameter int ADDR_W      = 4,
    parameter int BUSY_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [7:0]        wr_data_i,
    input  logic              ptr_load_i,
    input  logic [ADDR_W-1:0] ptr_val_i,
    input  logic              rd_adv_i,
    output logic [7:0]        rd_data_o,
    output logic              busy_o
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [7:0]        cells [DEPTH];
    logic [ADDR_W-1:0] ptr_q;
    logic [CNT_W-1:0]  busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
        end else if (wr_en_i) begin
            cells[ptr_q] <= wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                       ptr_q <= '0;
        else if (ptr_load_i)           ptr_q <= ptr_val_i;
        else if (wr_en_i || rd_adv_i)  ptr_q <= ptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                 busy_cnt <= '0;
        else if (wr_en_i)        busy_cnt <= CNT_W'(BUSY_CYCLES);
        else if (busy_cnt != 0)  busy_cnt <= busy_cnt - 1'b1;
    end

    assign rd_data_o = cells[ptr_q];
    assign busy_o    = (busy_cnt != 0);

    assert_busy_after_write_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> busy_o);

    assert_ptr_step_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en_i || rd_adv_i) && !$past(ptr_load_i))
            |-> ptr_q == ADDR_W'($past(ptr_q) + 1'b1));

    assert_ptr_load_R3: assert property (@(posedge clk) disable iff (rst)
        $past(ptr_load_i) |-> ptr_q == $past(ptr_val_i));

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import tiny_i2c_mem_pkg::*;
#(
    parameter int         ADDR_W = 4,
    parameter logic [6:0] DEV_ID = 7'h50
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              busy_i,
    input  logic [7:0]        rd_data_i,
    output logic              wr_en_o,
    output logic [7:0]        wr_data_o,
    output logic              ptr_load_o,
    output logic [ADDR_W-1:0] ptr_val_o,
    output logic              rd_adv_o,
    output logic              sda_oe_o
);
    eng_state_e state;
    seg_e       seg;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [7:0] txsh;
    logic       ack_q;
    logic       rw_q;
    logic       mack_q;
    logic       decide;
    logic       byte_ok;

    assign decide = (state == ENG_RX) && ev.scl_fall && (bitcnt == 4'd8);

    always_comb begin
        case (seg)
            SEG_CTRL: byte_ok = ctrl_hits(shreg, DEV_ID) && !busy_i;
            SEG_ADDR: byte_ok = addr_fits(shreg, ADDR_W);
            SEG_DATA: byte_ok = 1'b1;
            default:  byte_ok = 1'b0;
        endcase
    end

    assign wr_en_o    = decide && (seg == SEG_DATA);
    assign wr_data_o  = shreg;
    assign ptr_load_o = decide && (seg == SEG_ADDR) && byte_ok;
    assign ptr_val_o  = shreg[ADDR_W-1:0];
    assign rd_adv_o   = ev.scl_fall &&
                        (((state == ENG_RX_ACK) && ack_q && (seg == SEG_CTRL) && rw_q) ||
                         ((state == ENG_TX_ACK) && mack_q));
    assign sda_oe_o   = ((state == ENG_RX_ACK) && ack_q) ||
                        ((state == ENG_TX) && !txsh[7]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ENG_IDLE;
            seg    <= SEG_CTRL;
            bitcnt <= '0;
            shreg  <= '0;
            txsh   <= '0;
            ack_q  <= 1'b0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
        end else if (ev.start) begin
            state  <= ENG_RX;
            seg    <= SEG_CTRL;
            bitcnt <= '0;
        end else if (ev.stop) begin
            state  <= ENG_IDLE;
        end else begin
            case (state)
                ENG_RX: begin
                    if (ev.scl_rise && bitcnt != 4'd8) begin
                        shreg  <= {shreg[6:0], ev.sda_lvl};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (decide) begin
                        ack_q <= byte_ok;
                        if (seg == SEG_CTRL) rw_q <= shreg[0];
                        state <= ENG_RX_ACK;
                    end
                end
                ENG_RX_ACK: begin
                    if (ev.scl_fall) begin
                        bitcnt <= '0;
                        if (!ack_q) begin
                            state <= ENG_IGNORE;
                        end else if (seg == SEG_CTRL && rw_q) begin
                            state <= ENG_TX;
                            txsh  <= rd_data_i;
                        end else begin
                            state <= ENG_RX;
                            seg   <= seg_next(seg);
                        end
                    end
                end
                ENG_TX: begin
                    if (ev.scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            state  <= ENG_TX_ACK;
                            bitcnt <= '0;
                        end else begin
                            txsh   <= {txsh[6:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ENG_TX_ACK: begin
                    if (ev.scl_rise) mack_q <= ~ev.sda_lvl;
                    if (ev.scl_fall) begin
                        if (mack_q) begin
                            state <= ENG_TX;
                            txsh  <= rd_data_i;
                        end else begin
                            state <= ENG_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assert_ctrl_ack_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_RX_ACK && seg == SEG_CTRL && ack_q) |-> !busy_i);

    assert_no_store_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> !busy_i);

    assert_single_ptr_cmd_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en_o, ptr_load_o, rd_adv_o}));

endmodule

// File: rtl/tiny_i2c_mem.sv
module tiny_i2c_mem
    import tiny_i2c_mem_pkg::*;
#(
    parameter int         MEM_DEPTH   = 16,
    parameter int         BUSY_CYCLES = 1000,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ID      = 7'b1010000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int ADDR_W = $clog2(MEM_DEPTH);

    bus_ev_t           ev;
    logic              busy;
    logic [7:0]        rd_data;
    logic              wr_en;
    logic [7:0]        wr_data;
    logic              ptr_load;
    logic [ADDR_W-1:0] ptr_val;
    logic              rd_adv;

    i2c_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_byte_engine #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .busy_i     (busy),
        .rd_data_i  (rd_data),
        .wr_en_o    (wr_en),
        .wr_data_o  (wr_data),
        .ptr_load_o (ptr_load),
        .ptr_val_o  (ptr_val),
        .rd_adv_o   (rd_adv),
        .sda_oe_o   (sda_oe)
    );

    i2c_mem_array #(
        .DEPTH       (MEM_DEPTH),
        .ADDR_W      (ADDR_W),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_mem (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .ptr_load_i (ptr_load),
        .ptr_val_i  (ptr_val),
        .rd_adv_i   (rd_adv),
        .rd_data_o  (rd_data),
        .busy_o     (busy)
    );

    assert_sda_quiet_scl_high_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(ev.scl_lvl) && !$past(ev.start) && !$past(ev.stop)) |-> $stable(sda_oe));

endmodule

// File: tb/test_tiny_i2c_mem.sv
module test_tiny_i2c_mem;

    localparam int BUSY = 1000;
    localparam int Q    = 5;
    localparam int WD   = 150000;
    localparam logic [11:0] VECS [6] = '{12'h03C, 12'h7A5, 12'hF81,
                                         12'h100, 12'h9FF, 12'hE5A};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_bus;
    int   checks = 0;
    int   failures = 0;
    int   viol = 0;
    logic scl_q = 1'b1;
    logic oe_q = 1'b0;
    logic [7:0] exp_mem [16];

    assign sda_bus = m_sda & ~sda_oe;

    always #10 clk = ~clk;

    tiny_i2c_mem #(.BUSY_CYCLES(BUSY)) i_tiny_i2c_mem (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (m_scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe)
    );

    // R10 monitor: drive must not move while the bus clock stays high
    always @(negedge clk) begin
        if (!rst && m_scl && scl_q && (sda_oe !== oe_q)) viol++;
        scl_q <= m_scl;
        oe_q  <= sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(2 * Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        acked = (sda_bus == 1'b0);
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            b[i] = sda_bus;
            tick(Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = give_ack ? 1'b0 : 1'b1; tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    task automatic write_one(input logic [3:0] a, input logic [7:0] d, output logic ok);
        logic k1, k2, k3;
        bus_start();
        send_byte(8'hA0, k1);
        send_byte({4'h0, a}, k2);
        send_byte(d, k3);
        bus_stop();
        ok = k1 & k2 & k3;
        if (ok) exp_mem[a] = d;
    endtask

    task automatic set_ptr(input logic [3:0] a);
        logic k;
        bus_start();
        send_byte(8'hA0, k);
        send_byte({4'h0, a}, k);
        bus_stop();
    endtask

    task automatic read_cur(output logic [7:0] d, output logic acked);
        bus_start();
        send_byte(8'hA1, acked);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin
        logic       ok;
        logic [7:0] d;
        for (int i = 0; i < 16; i++) exp_mem[i] = 8'h00;
        tick(5);
        rst = 1'b0;
        tick(5);

        // R1: reset state at the pins
        chk("R1 sda_oe after reset", sda_oe, 0);
        chk("R1 bus released", sda_bus, 1);
        read_cur(d, ok);
        chk("R2 read control ack", ok, 1);
        chk("R1 location 0 after reset", d, 8'h00);

        // Table walk: R4 store, R3 pointer load, R6 read back
        foreach (VECS[v]) begin
            write_one(VECS[v][11:8], VECS[v][7:0], ok);
            chk("R4 write acked", ok, 1);
            tick(BUSY + 50);
            set_ptr(VECS[v][11:8]);
            read_cur(d, ok);
            chk("R3 R6 read back", d, VECS[v][7:0]);
        end

        // R2: foreign control byte refused, slave silent afterwards
        bus_start();
        send_byte(8'hA4, ok);
        chk("R2 wrong id nack", ok, 0);
        send_byte(8'h00, ok);
        chk("R2 silent after nack", ok, 0);
        bus_stop();
        bus_start();
        send_byte(8'hE0, ok);
        chk("R2 wrong upper bits nack", ok, 0);
        bus_stop();

        // R3: bad address byte refused, pointer kept
        set_ptr(4'h7);
        bus_start();
        send_byte(8'hA0, ok);
        send_byte(8'h35, ok);
        chk("R3 bad address nack", ok, 0);
        bus_stop();
        read_cur(d, ok);
        chk("R3 pointer unchanged", d, exp_mem[7]);

        // R5: second data byte refused and not stored
        bus_start();
        send_byte(8'hA0, ok);
        send_byte(8'h03, ok);
        send_byte(8'h11, ok);
        chk("R4 first data ack", ok, 1);
        exp_mem[3] = 8'h11;
        send_byte(8'h22, ok);
        chk("R5 extra data nack", ok, 0);
        bus_stop();
        tick(BUSY + 50);
        set_ptr(4'h3);
        bus_start();
        send_byte(8'hA1, ok);
        recv_byte(1'b1, d);
        chk("R4 stored byte", d, 8'h11);
        recv_byte(1'b0, d);
        chk("R5 next location untouched", d, exp_mem[4]);
        bus_stop();

        // R7: write at 15 wraps the pointer to 0
        write_one(4'hF, 8'h77, ok);
        tick(BUSY + 50);
        read_cur(d, ok);
        chk("R7 write wrap to 0", d, exp_mem[0]);

        // R6 R7: sequential read across the wrap, then release after NACK
        set_ptr(4'hE);
        bus_start();
        send_byte(8'hA1, ok);
        recv_byte(1'b1, d);
        chk("R6 seq byte 14", d, exp_mem[14]);
        recv_byte(1'b1, d);
        chk("R6 seq byte 15", d, exp_mem[15]);
        recv_byte(1'b0, d);
        chk("R7 seq wrap to 0", d, exp_mem[0]);
        chk("R6 released after nack", sda_bus, 1);
        recv_byte(1'b0, d);
        chk("R6 silent after nack", d, 8'hFF);
        bus_stop();

        // R8: polling during the write cycle
        write_one(4'h2, 8'h42, ok);
        bus_start();
        send_byte(8'hA0, ok);
        chk("R8 write poll nack while busy", ok, 0);
        bus_stop();
        bus_start();
        send_byte(8'hA1, ok);
        chk("R8 read poll nack while busy", ok, 0);
        bus_stop();
        tick(BUSY);
        bus_start();
        send_byte(8'hA0, ok);
        chk("R8 poll ack after cycle", ok, 1);
        bus_stop();
        set_ptr(4'h2);
        read_cur(d, ok);
        chk("R8 written byte present", d, 8'h42);

        // R9: start in mid-byte, then a repeated start for a random read
        bus_start();
        for (int i = 7; i >= 4; i--) begin
            m_sda = VECS[0][i]; tick(Q);
            m_scl = 1'b1; tick(2 * Q);
            m_scl = 1'b0; tick(Q);
        end
        bus_start();
        send_byte(8'hA0, ok);
        chk("R9 control after mid-byte start", ok, 1);
        send_byte(8'h09, ok);
        bus_start();
        send_byte(8'hA1, ok);
        chk("R9 repeated start ack", ok, 1);
        recv_byte(1'b0, d);
        chk("R9 random read", d, exp_mem[9]);
        bus_stop();

        chk("R10 drive steady while clock high", viol, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule